// File: doc/BRIEF.md
# UART Baud Tick Generator with Source Selection

This block produces the single-cycle baud enable that an 8051-style enhanced UART uses for its shift logic. It picks one of three rate sources. The first is a fixed divide of the core clock. The second is a prescaler that counts external timer-1 overflow strobes. The third is a programmable 16-bit generator whose period is the programmed value plus a constant offset of 16. The UART mode bits and a double-rate bit choose the source and the divide ratio. A control register holds a generator enable and a source-select bit. The select bit applies only in the two variable-rate modes.

Software reaches the block through a byte-wide write port. Address 0 is the control register, with bit 0 as the generator enable and bit 1 as the generator select. Addresses 1 and 2 are the low and high bytes of the rate. The rate bytes are locked while the generator runs. A write that arrives during that time is dropped and sets a sticky fault flag. Any change of the mode bits or the select bit restarts every divider, so the first tick after a change always comes one full period later.

Top module: `uart_baud_tick_gen`

## Requirements
- R1: With the generator selected and enabled, ticks repeat every (rate + 16) core clock cycles. The rate is formed as {byte at address 2, byte at address 1}. The double-rate bit has no effect on this period.
- R2: Control bit 1 = 1 selects the generator and 0 selects the timer-1 path. The selection is honoured only when the mode bits are 01 or 11.
- R3: With mode bits 00, ticks repeat every 16 cycles, whatever the double-rate, select and enable bits are.
- R4: With mode bits 10, ticks repeat every 32 cycles when the double-rate bit is 0 and every 16 cycles when it is 1.
- R5: On the timer-1 path, one tick is produced per 32 overflow strobes when the double-rate bit is 0, and per 16 strobes when it is 1.
- R6: A write to address 1 or 2 while control bit 0 is 1 leaves the rate unchanged.
- R7: Such a write sets the fault output. The fault output then stays at 1 until reset.
- R8: Enabling the generator with a write to control bit 0 starts a full period. The first tick is registered at the (P+1)th rising edge after the edge that captures the write, where P = rate + 16.
- R9: A change of the mode bits or the select bit restarts all dividers. A tick that would fall on the edge that samples the change is suppressed. The next tick is registered at the (P+1)th edge after that edge, where P is the new period.
- R10: With mode bits 01 or 11, the generator selected and control bit 0 = 0, no tick is produced.
- R11: Synchronous reset clears the rate, the control register and the fault flag, and holds the tick low. After reset the timer-1 path is the active variable-rate source.
- R12: Every tick is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 rate low byte, 2 rate high byte |
| wr_data | input | 8 | Write data |
| uart_mode | input | 2 | UART mode bits |
| dbl_rate | input | 1 | Double-rate control bit |
| t1_ovf | input | 1 | Timer-1 overflow strobe, one cycle per overflow |
| baud_tick | output | 1 | Single-cycle baud enable |
| wr_fault | output | 1 | Sticky flag: a rate byte was written while the generator was enabled |

## Verification
The two functions that can land on the same clock edge are the terminal-count reload of a divider and the restart caused by a mode change. The bench first locks onto the 16-cycle fixed rate. It then switches the mode bits so that they are sampled on exactly the edge where the next tick would be registered. The bench judges the result at the output: no tick may appear on that edge, and the first tick must come a full new period plus one cycle after the change. Because no tick appears early, the terminal pulse is shown to be suppressed rather than passed through.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_RATE0 = 2'd1;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEL_BIT = 1;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_FIXED = 2'd1,
    SRC_TIMER = 2'd2,
    SRC_GEN   = 2'd3
  } baud_src_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [RATE_W-1:0] rate_q,
  output logic              gen_en,
  output logic              gen_sel,
  output logic              wr_fault
);
  localparam int NBYTES = RATE_W / DATA_W;

  logic is_rate;

  always_comb begin
    is_rate = (wr_addr >= ADR_RATE0) &&
              (int'(wr_addr) < int'(ADR_RATE0) + NBYTES);
  end

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en  <= 1'b0;
      gen_sel <= 1'b0;
    end else if (wr_en && wr_addr == ADR_CTRL) begin
      gen_en  <= wr_data[CTRL_EN_BIT];
      gen_sel <= wr_data[CTRL_SEL_BIT];
    end
  end

  // rate bytes, writable only while the generator is stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
    end else if (wr_en && !gen_en) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_addr == ADR_RATE0 + ADDR_W'(b))
          rate_q[b*DATA_W +: DATA_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      wr_fault <= 1'b0;
    else if (wr_en && is_rate && gen_en)
      wr_fault <= 1'b1;
  end

  // R6: rate is frozen while the generator runs
  p_rate_locked_r6: assert property (@(posedge clk) disable iff (rst)
    gen_en |=> $stable(rate_q));
  // R7: a locked write raises the flag
  p_fault_set_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_rate && gen_en) |=> wr_fault);
  // R7: the flag is sticky
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (rst)
    wr_fault |=> wr_fault);
endmodule

// File: rtl/baud_div.sv
module baud_div #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] period_m1,
  output logic             pulse_q
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q   <= period_m1;
      pulse_q <= 1'b0;
    end else if (step) begin
      if (cnt_q == '0) begin
        cnt_q   <= period_m1;
        pulse_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q - 1'b1;
        pulse_q <= 1'b0;
      end
    end else begin
      pulse_q <= 1'b0;
    end
  end

  // R12: a reload never yields back-to-back pulses
  p_pulse_once_r12: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && period_m1 != '0) |=> !pulse_q);
  // R9: a clear silences the divider for the next cycle
  p_clr_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !pulse_q);
endmodule

// File: rtl/uart_baud_tick_gen.sv
module uart_baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RATE_W   = 16,
  parameter int RATE_OFS = 16,
  parameter int DIV_FAST = 16,
  parameter int DIV_SLOW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        uart_mode,
  input  logic              dbl_rate,
  input  logic              t1_ovf,
  output logic              baud_tick,
  output logic              wr_fault
);
  localparam int GEN_W = RATE_W + 1;
  localparam int FIX_W = $clog2(DIV_SLOW + 1);

  logic [RATE_W-1:0] rate_q;
  logic              gen_en, gen_sel;
  logic [1:0]        prev_mode;
  logic              prev_sel;
  logic              restart;
  logic [FIX_W-1:0]  fix_per_m1, tmr_per_m1;
  logic [GEN_W-1:0]  gen_per_m1;
  logic              fix_pulse, tmr_pulse, gen_pulse, sel_pulse;
  baud_src_e         src;

  baud_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rate_q(rate_q), .gen_en(gen_en),
    .gen_sel(gen_sel), .wr_fault(wr_fault)
  );

  // change detection on mode and select
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_mode <= 2'b00;
      prev_sel  <= 1'b0;
    end else begin
      prev_mode <= uart_mode;
      prev_sel  <= gen_sel;
    end
  end

  always_comb begin
    restart    = (uart_mode != prev_mode) || (gen_sel != prev_sel);
    fix_per_m1 = (uart_mode == 2'b10 && !dbl_rate) ? FIX_W'(DIV_SLOW - 1)
                                                   : FIX_W'(DIV_FAST - 1);
    tmr_per_m1 = dbl_rate ? FIX_W'(DIV_FAST - 1) : FIX_W'(DIV_SLOW - 1);
    gen_per_m1 = GEN_W'(rate_q) + GEN_W'(RATE_OFS - 1);
  end

  baud_div #(.CNT_W(FIX_W)) u_fix (
    .clk(clk), .rst(rst), .clr(restart), .step(1'b1),
    .period_m1(fix_per_m1), .pulse_q(fix_pulse)
  );

  baud_div #(.CNT_W(FIX_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(restart), .step(t1_ovf),
    .period_m1(tmr_per_m1), .pulse_q(tmr_pulse)
  );

  baud_div #(.CNT_W(GEN_W)) u_gen (
    .clk(clk), .rst(rst), .clr(restart || !gen_en), .step(1'b1),
    .period_m1(gen_per_m1), .pulse_q(gen_pulse)
  );

  always_comb begin
    if (!uart_mode[0])
      src = SRC_FIXED;
    else if (!gen_sel)
      src = SRC_TIMER;
    else if (gen_en)
      src = SRC_GEN;
    else
      src = SRC_NONE;
  end

  always_comb begin
    case (src)
      SRC_FIXED: sel_pulse = fix_pulse;
      SRC_TIMER: sel_pulse = tmr_pulse;
      SRC_GEN:   sel_pulse = gen_pulse;
      default:   sel_pulse = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      baud_tick <= 1'b0;
    else
      baud_tick <= restart ? 1'b0 : sel_pulse;
  end

  // R12: one-cycle tick
  p_tick_width_r12: assert property (@(posedge clk) disable iff (rst)
    baud_tick |=> !baud_tick);
  // R9: nothing escapes on the cycle after a restart
  p_restart_gap_r9: assert property (@(posedge clk) disable iff (rst)
    restart |=> !baud_tick);
  // R10: stopped generator yields no tick
  p_gen_off_r10: assert property (@(posedge clk) disable iff (rst)
    (uart_mode[0] && gen_sel && !gen_en && !$past(gen_en)) |=> !baud_tick);
endmodule

// File: tb/test_uart_baud_tick_gen.sv
`timescale 1ns/1ps
module test_uart_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] uart_mode;
  logic       dbl_rate;
  logic       t1_ovf;
  logic       baud_tick;
  logic       wr_fault;

  int n_checks = 0;
  int n_fail   = 0;
  int strobe_k = 3;
  int strobe_c = 0;

  always #4 clk = ~clk;  // 125 MHz

  uart_baud_tick_gen i_uart_baud_tick_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .uart_mode(uart_mode), .dbl_rate(dbl_rate),
    .t1_ovf(t1_ovf), .baud_tick(baud_tick), .wr_fault(wr_fault)
  );

  // timer-1 overflow strobe: one cycle in every strobe_k
  initial begin
    t1_ovf = 1'b0;
    forever begin
      @(negedge clk);
      strobe_c++;
      t1_ovf = (strobe_k != 0) && (strobe_c % strobe_k == 0);
    end
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic        dbl;
    logic        sel;
    logic        en;
    logic [15:0] rate;
    logic [3:0]  k;
    logic [11:0] per;   // 0 = no tick expected
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3, 12'd16},   // R3
    '{2'd0, 1'b1, 1'b1, 1'b1, 16'h0020, 4'd3, 12'd16},   // R3 other bits ignored
    '{2'd2, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3, 12'd32},   // R4
    '{2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd3, 12'd16},   // R4
    '{2'd1, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd3, 12'd96},   // R5 R2
    '{2'd1, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd3, 12'd48},   // R5 R2
    '{2'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd2, 12'd64},   // R5 R2
    '{2'd1, 1'b0, 1'b1, 1'b1, 16'h0000, 4'd3, 12'd16},   // R1 R2
    '{2'd3, 1'b1, 1'b1, 1'b1, 16'h0105, 4'd3, 12'd277},  // R1
    '{2'd1, 1'b0, 1'b1, 1'b1, 16'h0040, 4'd3, 12'd80},   // R1 double-rate ignored
    '{2'd1, 1'b0, 1'b1, 1'b0, 16'h0040, 4'd3, 12'd0}     // R10
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(output int n, input int lim);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick && n < lim);
  endtask

  initial begin
    #1200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00;
    uart_mode = 2'd1; dbl_rate = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 tick in reset", int'(baud_tick), 0);
    check("R11 fault in reset", int'(wr_fault), 0);
    rst = 1'b0;
    // R11: default is timer path, k=3, dbl=1 -> 48
    measure(n, 1000);
    measure(n, 1000);
    check("R11 default timer period", n, 48);
    @(negedge clk);
    check("R12 tick width", int'(baud_tick), 0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {6'd0, VECS[i].sel, 1'b0});
      wr(2'd1, VECS[i].rate[7:0]);
      wr(2'd2, VECS[i].rate[15:8]);
      uart_mode = VECS[i].mode;
      dbl_rate  = VECS[i].dbl;
      strobe_k  = int'(VECS[i].k);
      wr(2'd0, {6'd0, VECS[i].sel, VECS[i].en});
      if (VECS[i].per != 0) begin
        measure(n, 1000);
        measure(n, 1000);
        check($sformatf("vector %0d period", i), n, int'(VECS[i].per));
      end else begin
        measure(n, 400);
        check($sformatf("vector %0d R10 silence", i), n, 400);
      end
    end
    check("R7 fault after legal writes", int'(wr_fault), 0);

    // R8: enable latency, rate 4 -> P=20, first tick at P+1
    uart_mode = 2'd1; dbl_rate = 1'b0;
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h04);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h03);
    measure(n, 1000);
    check("R8 first tick after enable", n, 21);

    // R6/R7: locked write
    wr(2'd1, 8'hF0);
    check("R7 fault set", int'(wr_fault), 1);
    measure(n, 1000);
    measure(n, 1000);
    check("R6 period after locked write", n, 20);
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h03);
    measure(n, 1000);
    check("R6 rate kept after re-enable", n, 21);
    check("R7 fault sticky", int'(wr_fault), 1);

    // R9: mode change on the edge of a due tick
    uart_mode = 2'd0;
    measure(n, 1000);
    measure(n, 1000);
    check("R3 fixed period", n, 16);
    repeat (15) @(negedge clk);
    uart_mode = 2'd2; dbl_rate = 1'b0;
    measure(n, 1000);
    check("R9 restart latency", n, 34);
    measure(n, 1000);
    check("R4 period after restart", n, 32);

    // R11: reset clears fault
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 fault cleared", int'(wr_fault), 0);
    check("R11 tick low", int'(baud_tick), 0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule